// File: doc/BRIEF.md
# Serial Memory Write Protection Unit

This block keeps the protection state of a serial memory device and decides, for every write attempt, whether it may proceed. It holds a write enable latch, a two-bit block protect field and a protect enable bit, and it takes an active-low hardware write-protect pin. It receives decoded strobes from a serial command decoder: set the latch, clear the latch, a memory array write with its address, and a status register write with its data byte.

Memory array writes are gated only by the latch and the block protect field. Status register writes are gated by the latch and by the protect enable bit combined with the pin. The pin is captured when chip select falls, so a pin change during a frame has no effect until the next frame begins. After any frame that carried a write strobe, the latch clears when chip select rises, so every write needs a fresh enable command. The block also presents the status byte for reads.

Top module: `serial_wp_unit`

## Requirements
- R1: After reset the latch, the block protect field and the protect enable bit are 0, so status_rd reads 8'h00 and both grant outputs are 0.
- R2: A set strobe (wren) in a frame sets the latch and a clear strobe (wrdi) clears it from the next cycle. When both arrive in one cycle, the clear wins. Strobes while cs_n is high are ignored.
- R3: With the latch at 1, mem_wr_ok reports whether mem_addr lies outside the protected range. Block protect 2'b00 protects nothing, 2'b01 protects 6000h-7FFFh, 2'b10 protects 4000h-7FFFh and 2'b11 protects the whole 15-bit space.
- R4: With the latch at 0, both mem_wr_ok and sr_wr_ok are 0 whatever the address, the pin and the other bits.
- R5: With the latch at 1 and the protect enable bit at 0, sr_wr_ok is 1 at either pin level.
- R6: With the latch at 1, the protect enable bit at 1 and a captured pin level of 0, sr_wr_ok is 0 while memory outside the protected range stays writable.
- R7: wp_n is captured at the cycle where cs_n falls. Later changes within the same frame do not alter sr_wr_ok.
- R8: An accepted status write loads the protect enable bit from sr_wdata[7] and the block protect field from sr_wdata[3:2] on the next cycle. A blocked status write changes neither.
- R9: When cs_n rises after a frame that carried a mem_wr or sr_wr strobe, the latch clears. A frame with no write strobe leaves the latch as it is.
- R10: status_rd carries the protect enable bit at bit 7, the block protect field at bits 3:2 and the latch at bit 1. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low; low marks a frame |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| wren | input | 1 | Decoded set-latch command strobe |
| wrdi | input | 1 | Decoded clear-latch command strobe |
| mem_wr | input | 1 | Memory array write strobe |
| mem_addr | input | 15 | Address of the memory write being checked |
| sr_wr | input | 1 | Status register write strobe |
| sr_wdata | input | 8 | Data byte of the status register write |
| mem_wr_ok | output | 1 | Memory write at mem_addr is allowed |
| sr_wr_ok | output | 1 | Status register write is allowed |
| status_rd | output | 8 | Status byte for reads |

## Verification
The set and clear commands can land in the same cycle, and the bench provokes this by raising wren and wrdi together inside a frame, then reads bit 1 of status_rd a cycle later and expects 0. A second overlap is a pin edge inside a frame that follows a capture at the falling edge of chip select. The bench moves wp_n both ways mid-frame and expects sr_wr_ok to follow only the level captured at the frame start, then opens a fresh frame to confirm that the new level takes effect.

// File: rtl/serial_wp_unit.sv
module serial_wp_unit #(
  parameter int ADDR_W   = 15,
  parameter int SR_W     = 8,
  parameter int WPEN_POS = 7,
  parameter int BP_POS   = 2,
  parameter int WEL_POS  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wp_n,
  input  logic              wren,
  input  logic              wrdi,
  input  logic              mem_wr,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic              sr_wr,
  input  logic [SR_W-1:0]   sr_wdata,
  output logic              mem_wr_ok,
  output logic              sr_wr_ok,
  output logic [SR_W-1:0]   status_rd
);

  logic       wel, wpen, cs_q, wp_q, wr_seen, prot_hit;
  logic [1:0] bp;

  wire cs_fall  = cs_q & ~cs_n;
  wire cs_rise  = ~cs_q & cs_n;
  wire wren_v   = wren & ~cs_n;
  wire wrdi_v   = wrdi & ~cs_n;
  wire mem_wr_v = mem_wr & ~cs_n;
  wire sr_wr_v  = sr_wr & ~cs_n;
  wire wp_eff   = cs_fall ? wp_n : wp_q;

  always_comb begin
    case (bp)
      2'b00:   prot_hit = 1'b0;
      2'b01:   prot_hit = &mem_addr[ADDR_W-1 -: 2];
      2'b10:   prot_hit = mem_addr[ADDR_W-1];
      default: prot_hit = 1'b1;
    endcase
  end

  assign mem_wr_ok = wel & ~prot_hit;
  assign sr_wr_ok  = wel & ~(wpen & ~wp_eff);

  always_comb begin
    status_rd = '0;
    status_rd[WPEN_POS]         = wpen;
    status_rd[BP_POS +: 2]      = bp;
    status_rd[WEL_POS]          = wel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= 1'b1;
      wp_q    <= 1'b1;
      wr_seen <= 1'b0;
      wel     <= 1'b0;
      wpen    <= 1'b0;
      bp      <= 2'b00;
    end else begin
      cs_q <= cs_n;
      if (cs_fall) wp_q <= wp_n;
      if (cs_rise)                   wr_seen <= 1'b0;
      else if (mem_wr_v || sr_wr_v)  wr_seen <= 1'b1;
      if (cs_rise && wr_seen) wel <= 1'b0;
      else if (wrdi_v)        wel <= 1'b0;
      else if (wren_v)        wel <= 1'b1;
      if (sr_wr_v && sr_wr_ok) begin
        wpen <= sr_wdata[WPEN_POS];
        bp   <= sr_wdata[BP_POS +: 2];
      end
    end
  end

  // R2: clear strobe dominates
  a_r2_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wrdi_v |=> !status_rd[WEL_POS]);

  a_r9_frame_end_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && wr_seen) |=> !status_rd[WEL_POS]);

  a_r7_pin_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !cs_q && !$past(cs_q)) |-> $stable(wp_q));

  a_r8_sr_load: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_wr_v && sr_wr_ok) |=> (status_rd[WPEN_POS] == $past(sr_wdata[WPEN_POS])
                               && status_rd[BP_POS +: 2] == $past(sr_wdata[BP_POS +: 2])));

  a_r8_sr_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_wr_v && !sr_wr_ok) |=> ($stable(wpen) && $stable(bp)));

  a_r4_no_grant_unlatched: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_rd[WEL_POS]) |-> (!mem_wr_ok && !sr_wr_ok));

endmodule

// File: tb/test_serial_wp_unit.sv
module test_serial_wp_unit;
  logic clk = 0, rst_n = 0, cs_n = 1, wp_n = 1, wren = 0, wrdi = 0, mem_wr = 0, sr_wr = 0;
  logic [14:0] mem_addr = '0;
  logic [7:0]  sr_wdata = '0;
  logic        mem_wr_ok, sr_wr_ok;
  logic [7:0]  status_rd;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  serial_wp_unit i_serial_wp_unit (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .wren(wren), .wrdi(wrdi),
    .mem_wr(mem_wr), .mem_addr(mem_addr), .sr_wr(sr_wr), .sr_wdata(sr_wdata),
    .mem_wr_ok(mem_wr_ok), .sr_wr_ok(sr_wr_ok), .status_rd(status_rd));

  typedef struct packed { logic [1:0] bp; logic [14:0] addr; logic ok; } vec_t;
  localparam vec_t VECS [10] = '{
    '{2'b00, 15'h0000, 1'b1}, '{2'b00, 15'h7FFF, 1'b1},
    '{2'b01, 15'h5FFF, 1'b1}, '{2'b01, 15'h6000, 1'b0},
    '{2'b01, 15'h7FFF, 1'b0}, '{2'b01, 15'h0000, 1'b1},
    '{2'b10, 15'h3FFF, 1'b1}, '{2'b10, 15'h4000, 1'b0},
    '{2'b11, 15'h0000, 1'b0}, '{2'b11, 15'h1234, 1'b0}};

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic open_frame(logic pin);
    cs_n = 0; wp_n = pin; @(negedge clk);
  endtask
  task automatic close_frame();
    cs_n = 1; @(negedge clk); @(negedge clk);
  endtask
  task automatic cmd(logic s, logic c);
    wren = s; wrdi = c; @(negedge clk); wren = 0; wrdi = 0;
  endtask
  task automatic sr_write(logic [7:0] d);
    sr_wdata = d; sr_wr = 1; @(negedge clk); sr_wr = 0;
  endtask
  task automatic mem_write(logic [14:0] a);
    mem_addr = a; mem_wr = 1; @(negedge clk); mem_wr = 0;
  endtask
  task automatic set_status(logic [7:0] d);
    open_frame(1); cmd(1, 0); close_frame();
    open_frame(1); sr_write(d); close_frame();
  endtask
  task automatic arm();
    open_frame(1); cmd(1, 0); close_frame();
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    check("R1 status", status_rd, 8'h00);
    check("R1 mem_ok", mem_wr_ok, 0);
    check("R1 sr_ok", sr_wr_ok, 0);

    // R3 table walk
    foreach (VECS[i]) begin
      set_status({6'b0, VECS[i].bp, 2'b00});
      arm();
      mem_addr = VECS[i].addr; #1;
      check("R3 mem_ok", mem_wr_ok, VECS[i].ok);
      @(negedge clk);
    end

    // R4: latch clear, nothing protected
    set_status(8'h00);
    mem_addr = 15'h0100; #1;
    check("R4 mem_ok", mem_wr_ok, 0);
    check("R4 sr_ok", sr_wr_ok, 0);
    @(negedge clk);

    // R2: strobes outside frame ignored; clear wins
    wren = 1; @(negedge clk); wren = 0; @(negedge clk);
    check("R2 idle wren", status_rd[1], 0);
    open_frame(1); cmd(1, 0);
    check("R2 set", status_rd[1], 1);
    cmd(1, 1);
    check("R2 clear wins", status_rd[1], 0);
    close_frame();

    // R9: frame without write keeps latch, write frame clears it
    arm();
    check("R9 kept", status_rd[1], 1);
    open_frame(1); mem_write(15'h0010); close_frame();
    check("R9 cleared", status_rd[1], 0);

    // R5: protect enable off, pin low
    open_frame(0); cmd(1, 0);
    check("R5 sr_ok", sr_wr_ok, 1);
    close_frame();

    // R6 and R8: lock status register
    set_status(8'h80);
    check("R8 wpen loaded", status_rd, 8'h80);
    open_frame(0); cmd(1, 0);
    check("R6 sr_ok", sr_wr_ok, 0);
    mem_addr = 15'h7FFF; #1;
    check("R6 mem_ok", mem_wr_ok, 1);
    @(negedge clk);
    sr_write(8'h0C);
    close_frame();
    check("R8 blocked", status_rd, 8'h80);

    // R7: pin captured at frame start
    open_frame(1); cmd(1, 0);
    wp_n = 0; @(negedge clk);
    check("R7 high held", sr_wr_ok, 1);
    close_frame();
    open_frame(0); cmd(1, 0);
    check("R7 new frame", sr_wr_ok, 0);
    wp_n = 1; @(negedge clk);
    check("R7 low held", sr_wr_ok, 0);
    close_frame();

    // R10: layout
    open_frame(1); cmd(1, 0); sr_write(8'hFF);
    check("R10 in frame", status_rd, 8'h8E);
    close_frame();
    check("R10 after frame", status_rd, 8'h8C);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule